// File: doc/BRIEF.md
# Power-Good Loss Classifier and Reboot Decision

This block sits in the always-on well of a platform and runs on the slow real-time clock. It watches three asynchronous inputs: a supply-rails-valid indication, the platform power-good signal and the standby-well reset. From them it produces a qualified power-good, which is held back for a programmable number of clock cycles after all three inputs are good. It also drives an internal reset that follows power-good for as long as power-good is low. No limit is placed on how long that reset can last.

The block tells apart two kinds of loss. A power-good drop with standby power still present is a momentary loss, for example a reset button wired into power-good. It sets a sticky status flag and always leads to a reboot. If the standby-well reset also goes low before power-good comes back, the loss is a full power failure. The status flag is then cleared, and a software-set policy input chooses between rebooting and staying off. The decision is issued as a single-cycle pulse in the cycle when qualified power-good next rises.

Top module: `pwr_loss_arbiter`

## Requirements
- R1: `rail_ok`, `pwr_good` and `stby_rst_n` are used only through two-flop synchronizers on `clk`. A low pulse that starts and ends between two rising edges of `clk` changes no output.
- R2: While `rst_n` is low, `pg_qual`, `pgfail_flag`, `reboot_req` and `stay_off` are 0 and `int_rst` is 1.
- R3: After `rail_ok`, `pwr_good` and `stby_rst_n` are all high ahead of a rising edge, `pg_qual` is still 0 after QUAL_CYCLES+1 edges and is 1 after QUAL_CYCLES+2 edges. If any of the three drops, `pg_qual` returns to 0 and the count starts again from zero.
- R4: A falling `pwr_good` while `stby_rst_n` stays high sets `pgfail_flag` 3 edges later. The flag stays set until `flag_clr` is sampled high at a rising edge, and it clears at that edge.
- R5: `int_rst` is 1 from the third edge after `pwr_good` (or `stby_rst_n`) goes low and stays 1 for as long as that input stays low. `pg_qual` is never 1 while `int_rst` is 1.
- R6: After a momentary loss (`stby_rst_n` high throughout), `reboot_req` pulses in the cycle `pg_qual` rises, whatever the value of `after_loss_on`.
- R7: If `stby_rst_n` goes low before `pwr_good` returns, `pgfail_flag` is cleared. When `pg_qual` next rises, `reboot_req` pulses if `after_loss_on` is 1 and `stay_off` pulses if it is 0.
- R8: `reboot_req` and `stay_off` are one cycle wide and never high together. A qualification with no loss recorded since reset or since the last decision produces neither pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow real-time clock; all sampling is on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| rail_ok | input | 1 | Supply rails reported valid (asynchronous) |
| pwr_good | input | 1 | Platform power-good (asynchronous) |
| stby_rst_n | input | 1 | Standby-well reset, active low (asynchronous) |
| after_loss_on | input | 1 | Policy after a full power failure: 1 reboot, 0 stay off |
| flag_clr | input | 1 | Synchronous clear of the status flag |
| pg_qual | output | 1 | Qualified power-good after the delay |
| pgfail_flag | output | 1 | Sticky momentary-power-good-loss status |
| reboot_req | output | 1 | One-cycle reboot decision pulse |
| stay_off | output | 1 | One-cycle stay-off decision pulse |
| int_rst | output | 1 | Internal reset, high while power-good or standby is low |

## Verification
The main function is tried with four loss patterns. A power-good dip with standby held high is run under both policy values, which shows whether the policy is ignored for momentary losses. A dip in which standby also falls is run under both policy values, which separates the reboot decision from the stay-off decision and shows that the status flag is cleared. A rail-only drop with power-good steady shows that the qualification count restarts without producing a decision. A power-good pulse narrower than one clock period shows that sub-period lows are invisible to the block.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_GLITCH = 2'd1,
        EV_FULL   = 2'd2
    } pfd_event_e;

    typedef struct packed {
        pfd_event_e ev;
        logic       pg_prev;
        logic       flag;
        logic       reboot;
        logic       stay;
    } pfd_track_s;

endpackage

// File: rtl/pfd_sync.sv
module pfd_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/pfd_qual_timer.sv
module pfd_qual_timer #(
    parameter int QUAL_CYCLES = 3277
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ok,
    output logic qual,
    output logic qual_rise
);

    localparam int CW = $clog2(QUAL_CYCLES + 1);
    localparam logic [CW-1:0] CNT_TOP  = CW'(QUAL_CYCLES);
    localparam logic [CW-1:0] CNT_LAST = CW'(QUAL_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!ok) begin
            cnt_d = '0;
        end else if (cnt_q != CNT_TOP) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign qual      = (cnt_q == CNT_TOP);
    assign qual_rise = ok && (cnt_q == CNT_LAST);

endmodule

// File: rtl/pfd_event_tracker.sv
module pfd_event_tracker
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pg_s,
    input  logic sb_s,
    input  logic policy,
    input  logic flag_clr,
    input  logic qual_rise,
    output logic flag,
    output logic reboot,
    output logic stay
);

    pfd_track_s trk_d, trk_q;
    logic       pg_fall;

    always_comb begin
        trk_d         = trk_q;
        trk_d.reboot  = 1'b0;
        trk_d.stay    = 1'b0;
        trk_d.pg_prev = pg_s;
        pg_fall       = trk_q.pg_prev && !pg_s;

        if (flag_clr) begin
            trk_d.flag = 1'b0;
        end

        if (!sb_s) begin
            trk_d.ev   = EV_FULL;
            trk_d.flag = 1'b0;
        end else if (pg_fall) begin
            if (trk_q.ev != EV_FULL) begin
                trk_d.ev   = EV_GLITCH;
                trk_d.flag = 1'b1;
            end
        end else if (qual_rise) begin
            unique case (trk_q.ev)
                EV_GLITCH: trk_d.reboot = 1'b1;
                EV_FULL: begin
                    trk_d.reboot = policy;
                    trk_d.stay   = !policy;
                end
                default: ;
            endcase
            trk_d.ev = EV_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '{ev: EV_NONE, pg_prev: 1'b0, flag: 1'b0,
                       reboot: 1'b0, stay: 1'b0};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign flag   = trk_q.flag;
    assign reboot = trk_q.reboot;
    assign stay   = trk_q.stay;

endmodule

// File: rtl/pwr_loss_arbiter.sv
module pwr_loss_arbiter #(
    parameter int QUAL_CYCLES = 3277,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rail_ok,
    input  logic pwr_good,
    input  logic stby_rst_n,
    input  logic after_loss_on,
    input  logic flag_clr,
    output logic pg_qual,
    output logic pgfail_flag,
    output logic reboot_req,
    output logic stay_off,
    output logic int_rst
);

    localparam int SW = 3;
    // bit 2 standby, bit 1 power-good, bit 0 rails; standby assumed present
    localparam logic [SW-1:0] SYNC_RST = 3'b100;

    logic [SW-1:0] raw_in, synced;
    logic          rail_s, pg_s, sb_s;
    logic          all_ok, qual_rise;
    logic          int_rst_d, int_rst_q;

    assign raw_in = {stby_rst_n, pwr_good, rail_ok};

    pfd_sync #(
        .WIDTH   (SW),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .dout  (synced)
    );

    assign rail_s = synced[0];
    assign pg_s   = synced[1];
    assign sb_s   = synced[2];
    assign all_ok = rail_s && pg_s && sb_s;

    pfd_qual_timer #(
        .QUAL_CYCLES (QUAL_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .ok        (all_ok),
        .qual      (pg_qual),
        .qual_rise (qual_rise)
    );

    pfd_event_tracker u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .pg_s      (pg_s),
        .sb_s      (sb_s),
        .policy    (after_loss_on),
        .flag_clr  (flag_clr),
        .qual_rise (qual_rise),
        .flag      (pgfail_flag),
        .reboot    (reboot_req),
        .stay      (stay_off)
    );

    always_comb begin
        int_rst_d = !(pg_s && sb_s);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_rst_q <= 1'b1;
        end else begin
            int_rst_q <= int_rst_d;
        end
    end

    assign int_rst = int_rst_q;

endmodule

// File: rtl/pwr_loss_arbiter_chk.sv
module pwr_loss_arbiter_chk (
    input logic clk,
    input logic rst_n,
    input logic after_loss_on,
    input logic pg_qual,
    input logic pgfail_flag,
    input logic reboot_req,
    input logic stay_off,
    input logic int_rst
);

    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(reboot_req && stay_off)); // R8

    AST_REBOOT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reboot_req |=> !reboot_req); // R8

    AST_STAY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stay_off |=> !stay_off); // R8

    AST_DECISION_AT_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (reboot_req || stay_off) |-> (pg_qual && !$past(pg_qual))); // R6

    AST_STAY_NEEDS_POLICY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        stay_off |-> !$past(after_loss_on)); // R7

    AST_NO_QUAL_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        int_rst |-> !pg_qual); // R5

    AST_FLAG_SET_WITH_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgfail_flag) |-> int_rst); // R4

endmodule

bind pwr_loss_arbiter pwr_loss_arbiter_chk u_chk (.*);

// File: tb/pwr_loss_arbiter_test.sv
module pwr_loss_arbiter_test;

    localparam int Q = 8;
    localparam int EXP_REBOOT = 1;
    localparam int EXP_STAY   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rail_ok = 1'b0, pwr_good = 1'b0, stby_rst_n = 1'b1;
    logic after_loss_on = 1'b0, flag_clr = 1'b0;
    logic pg_qual, pgfail_flag, reboot_req, stay_off, int_rst;

    int checks = 0;
    int errors = 0;
    int exp_q[$];

    always #4 clk = !clk;

    pwr_loss_arbiter #(.QUAL_CYCLES(Q)) uut (
        .clk(clk), .rst_n(rst_n), .rail_ok(rail_ok), .pwr_good(pwr_good),
        .stby_rst_n(stby_rst_n), .after_loss_on(after_loss_on),
        .flag_clr(flag_clr), .pg_qual(pg_qual), .pgfail_flag(pgfail_flag),
        .reboot_req(reboot_req), .stay_off(stay_off), .int_rst(int_rst)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // wait n rising edges, then sample 2 ns later
    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic push_decision(input int kind);
        exp_q.push_back(kind);
    endtask

    // monitor: pops one expected decision per observed pulse
    always @(negedge clk) begin
        if (rst_n && (reboot_req || stay_off)) begin
            checks++;
            if (reboot_req && stay_off) begin
                errors++;
                $display("FAIL R8: actual both pulses expected one");
            end else if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R8: actual %0d expected no decision",
                         reboot_req ? EXP_REBOOT : EXP_STAY);
            end else begin
                int e;
                e = exp_q.pop_front();
                if ((reboot_req ? EXP_REBOOT : EXP_STAY) != e) begin
                    errors++;
                    $display("FAIL R6/R7: actual %0d expected %0d",
                             reboot_req ? EXP_REBOOT : EXP_STAY, e);
                end
            end
        end
    end

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R2 reset state
        edges(3);
        chk("R2 pg_qual", pg_qual, 0);
        chk("R2 flag", pgfail_flag, 0);
        chk("R2 int_rst", int_rst, 1);
        chk("R2 pulses", reboot_req | stay_off, 0);
        @(negedge clk) rst_n = 1'b1;

        // R3 / R8 plain power-up, no decision expected
        @(negedge clk) begin rail_ok = 1'b1; pwr_good = 1'b1; end
        edges(Q + 1);
        chk("R3 early", pg_qual, 0);
        edges(1);
        chk("R3 on time", pg_qual, 1);
        chk("R5 int_rst released", int_rst, 0);

        // R4 R5 R6 momentary loss, policy off
        after_loss_on = 1'b0;
        @(negedge clk) pwr_good = 1'b0;
        edges(3);
        chk("R4 flag set", pgfail_flag, 1);
        chk("R5 int_rst", int_rst, 1);
        chk("R3 qual drop", pg_qual, 0);
        edges(40);
        chk("R5 int_rst held", int_rst, 1);
        push_decision(EXP_REBOOT);
        @(negedge clk) pwr_good = 1'b1;
        edges(Q + 3);
        chk("R6 qual back", pg_qual, 1);
        chk("R4 flag sticky", pgfail_flag, 1);
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        chk("R4 flag cleared", pgfail_flag, 0);

        // R6 momentary loss, policy on: still reboot
        after_loss_on = 1'b1;
        @(negedge clk) pwr_good = 1'b0;
        edges(6);
        push_decision(EXP_REBOOT);
        @(negedge clk) pwr_good = 1'b1;
        edges(Q + 3);
        chk("R6 flag", pgfail_flag, 1);
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;

        // R7 full failure, policy on
        after_loss_on = 1'b1;
        @(negedge clk) pwr_good = 1'b0;
        edges(5);
        @(negedge clk) stby_rst_n = 1'b0;
        edges(5);
        chk("R7 flag cleared", pgfail_flag, 0);
        @(negedge clk) stby_rst_n = 1'b1;
        edges(5);
        push_decision(EXP_REBOOT);
        @(negedge clk) pwr_good = 1'b1;
        edges(Q + 3);
        chk("R7 qual", pg_qual, 1);

        // R7 full failure, policy off
        after_loss_on = 1'b0;
        @(negedge clk) pwr_good = 1'b0;
        edges(4);
        @(negedge clk) stby_rst_n = 1'b0;
        edges(4);
        @(negedge clk) stby_rst_n = 1'b1;
        edges(4);
        push_decision(EXP_STAY);
        @(negedge clk) pwr_good = 1'b1;
        edges(Q + 3);
        chk("R7 flag stays clear", pgfail_flag, 0);

        // R3 rail drop restarts count, R8 no decision
        @(negedge clk) rail_ok = 1'b0;
        edges(3);
        chk("R3 rail drop", pg_qual, 0);
        @(negedge clk) rail_ok = 1'b1;
        edges(Q + 1);
        chk("R3 restart early", pg_qual, 0);
        edges(1);
        chk("R3 restart on time", pg_qual, 1);

        // R1 sub-period low pulse is invisible
        @(posedge clk);
        #1 pwr_good = 1'b0;
        #1 pwr_good = 1'b1;
        edges(5);
        chk("R1 flag", pgfail_flag, 0);
        chk("R1 int_rst", int_rst, 0);
        chk("R1 qual", pg_qual, 1);

        edges(4);
        chk("R8 queue drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule